// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder

This block is the command front end of a parallel NOR-style flash device with a 16-bit word interface. It watches host write cycles (word address, data, write strobe) and recognises the six-cycle chip-erase command. No other command is decoded. Once the command is accepted, a built-in erase engine runs over a small internal word array in two passes. The first pass forces every word to zero and the second pass sets every word to all ones.

While the engine runs, the block holds `busy` high. A host read during that time returns a status word in place of array data, so the host can poll for completion with plain reads. Writes made during the erase are discarded. The erase cannot be paused. Only the hardware reset input stops it, and that input also clears any partly entered command. When the erase finishes, the block goes back to normal array reads with no command state left behind. The system reset `rst_n` loads the array with a fixed power-up pattern.

Top module: `nor_erase_seq`

## Requirements
- R1: After `rst_n` is released, `busy` is 0 and a read of word i returns 16'h4C21 + i*16'h0137. Read data appears on `rdata` one clock after the `rd_en` cycle.
- R2: The erase starts only after six consecutive accepted writes. The required (word address, data) pairs, in order, are (555h,00AAh), (2AAh,0055h), (555h,0080h), (555h,00AAh), (2AAh,0055h), (555h,0010h). `busy` reads 1 on the clock after the sixth write.
- R3: A write whose address or data differs from the next expected pair sends the tracker back to its first step. The mismatching write is not reinterpreted, so no erase starts and the array is unchanged.
- R4: With no hardware reset, `busy` stays high for exactly 2*WORDS*CYC_PER_WORD clocks.
- R5: During a busy read, `rdata` is a status word. Bit 7 is 0, bits 6 and 2 both carry a toggle bit, and all other bits are 0. The first status read after the start returns 0000h, and the value then alternates between 0044h and 0000h on each busy read.
- R6: Writes made while `busy` is high are ignored. They neither restart nor lengthen the erase, and they leave no partial command state behind.
- R7: After a completed erase, every word reads FFFFh and reads return array data again.
- R8: Asserting `hw_reset` makes `busy` read 0 on the next clock. Words the engine has already written keep their new value and all other words keep their old value. A later full command then erases the whole array.
- R9: Asserting `hw_reset` while a command is partly entered clears the tracker, so the remaining cycles alone do not start an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset; loads the power-up array pattern |
| hw_reset | input | 1 | Synchronous hardware reset; aborts the erase and clears the command tracker |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, or the status word while busy |
| busy | output | 1 | High while the erase engine runs |

## Verification
A tracker left in a non-idle state shows up as a spurious start or a missing start. Either one makes `busy` differ from the expected value on the clock after the sixth write, or on the clock after a lone final-cycle write. A wrong pass or index counter changes the busy length or leaves a word that is not FFFFh, and the erase-length counts and the full-array readback expose this right after the run. Aborts at two chosen cycle offsets reveal an off-by-one in when words are written, as a mismatch at the boundary word between zeroed, erased and untouched words.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  localparam int DW      = 16;
  localparam int SEQ_LEN = 6;
  localparam int CMD_AW  = 11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ZERO = 2'd1,
    PH_WIPE = 2'd2
  } phase_t;

  // Word address expected at each step of the chip-erase command
  function automatic logic [CMD_AW-1:0] seq_addr(input int step);
    case (step)
      1, 4:    seq_addr = 11'h2AA;
      default: seq_addr = 11'h555;
    endcase
  endfunction

  // Data expected at each step of the chip-erase command
  function automatic logic [DW-1:0] seq_data(input int step);
    case (step)
      0, 3:    seq_data = 16'h00AA;
      1, 4:    seq_data = 16'h0055;
      2:       seq_data = 16'h0080;
      default: seq_data = 16'h0010;
    endcase
  endfunction

  // Power-up content of word idx
  function automatic logic [DW-1:0] seed_word(input int idx);
    seed_word = DW'(idx * 32'h0137 + 32'h4C21);
  endfunction

  // Status word returned by a read while busy
  function automatic logic [DW-1:0] status_word(input logic tgl);
    status_word = '0;
    status_word[6] = tgl;
    status_word[2] = tgl;
  endfunction

  // Clocks the engine stays busy for a full run
  function automatic int erase_cycles(input int words, input int cpw);
    erase_cycles = 2 * words * cpw;
  endfunction

endpackage

// File: rtl/nor_seq_tracker.sv
module nor_seq_tracker
  import nor_erase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [DW-1:0]     wdata,
  output logic              start
);

  localparam int SW = $clog2(SEQ_LEN);

  logic [SW-1:0] step;
  logic          live_wr;
  logic          hit;
  logic          last_step;

  assign live_wr   = wr_en && !busy && !hw_reset;
  assign hit       = (cmd_addr == seq_addr(int'(step))) && (wdata == seq_data(int'(step)));
  assign last_step = (step == SW'(SEQ_LEN - 1));
  assign start     = live_wr && hit && last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
    end else if (hw_reset) begin
      step <= '0;
    end else if (live_wr) begin
      if (hit && !last_step) step <= step + 1'b1;
      else                   step <= '0;
    end
  end

  // R6: no command state is held while the erase runs
  a_r6_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step == '0);

  // R3: a mismatching write leaves the tracker at its first step
  a_r3_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (live_wr && !hit) |=> step == '0);

  // R9: hardware reset clears a partly entered command
  a_r9_hwrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |=> step == '0);

endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine
  import nor_erase_pkg::*;
#(
  parameter int WORDS        = 16,
  parameter int CYC_PER_WORD = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hw_reset,
  input  logic                     start,
  output logic                     busy,
  output logic                     mem_we,
  output logic [$clog2(WORDS)-1:0] mem_idx,
  output logic [DW-1:0]            mem_wdata
);

  localparam int IW    = $clog2(WORDS);
  localparam int CW    = (CYC_PER_WORD > 1) ? $clog2(CYC_PER_WORD) : 1;
  localparam int TOTAL = erase_cycles(WORDS, CYC_PER_WORD);
  localparam int RW    = $clog2(TOTAL + 1);

  phase_t        phase;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          word_done;
  logic          last_word;

  assign busy      = (phase != PH_IDLE);
  assign word_done = busy && (cnt == CW'(CYC_PER_WORD - 1));
  assign last_word = (idx == IW'(WORDS - 1));
  assign mem_we    = word_done && !hw_reset;
  assign mem_idx   = idx;
  assign mem_wdata = (phase == PH_ZERO) ? '0 : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      cnt   <= '0;
    end else if (hw_reset) begin
      phase <= PH_IDLE;
      idx   <= '0;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_ZERO;
        idx   <= '0;
        cnt   <= '0;
      end
    end else if (word_done) begin
      cnt <= '0;
      if (last_word) begin
        idx   <= '0;
        phase <= (phase == PH_ZERO) ? PH_WIPE : PH_IDLE;
      end else begin
        idx <= idx + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Run-length counter kept only for the duration checks
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (!busy) run_len <= '0;
    else            run_len <= run_len + 1'b1;
  end

  // R2: an accepted command raises busy on the next clock
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hw_reset) |=> busy);

  // R8: hardware reset drops busy on the next clock
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |=> !busy);

  // R4: an unaborted run lasts exactly TOTAL clocks
  a_r4_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(hw_reset)) |-> $past(run_len) == RW'(TOTAL - 1));

  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < RW'(TOTAL));

  // R7: the wipe pass writes ones, the zero pass writes zeros
  a_r7_pass_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == '0) != (phase == PH_WIPE));

endmodule

// File: rtl/nor_word_store.sv
module nor_word_store
  import nor_erase_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hw_reset,
  input  logic                     busy,
  input  logic                     start,
  input  logic                     rd_en,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            rdata
);

  logic [DW-1:0] mem [WORDS];
  logic          tgl;
  logic          busy_rd;

  assign busy_rd = rd_en && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= seed_word(i);
    end else if (we) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tgl <= 1'b0;
    else if (hw_reset || start) tgl <= 1'b0;
    else if (busy_rd)          tgl <= ~tgl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_en)   rdata <= busy ? status_word(tgl) : mem[rd_idx];
  end

  // R5: status reads keep bit 7 low and bits 6 and 2 equal
  a_r5_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rd |=> (rdata[7] == 1'b0) && (rdata[6] == rdata[2]));

  // R5: back-to-back status reads flip the toggle bit
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    (busy_rd && $past(busy_rd)) |=> rdata[6] != $past(rdata[6]));

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int WORDS        = 16,
  parameter int CYC_PER_WORD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              busy
);

  localparam int IW = $clog2(WORDS);

  logic          start;
  logic          mem_we;
  logic [IW-1:0] mem_idx;
  logic [DW-1:0] mem_wdata;

  nor_seq_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_reset (hw_reset),
    .busy     (busy),
    .wr_en    (wr_en),
    .cmd_addr (addr[CMD_AW-1:0]),
    .wdata    (wdata),
    .start    (start)
  );

  nor_erase_engine #(
    .WORDS        (WORDS),
    .CYC_PER_WORD (CYC_PER_WORD)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_reset  (hw_reset),
    .start     (start),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_idx   (mem_idx),
    .mem_wdata (mem_wdata)
  );

  nor_word_store #(
    .WORDS (WORDS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_reset (hw_reset),
    .busy     (busy),
    .start    (start),
    .rd_en    (rd_en),
    .rd_idx   (addr[IW-1:0]),
    .we       (mem_we),
    .wr_idx   (mem_idx),
    .wr_data  (mem_wdata),
    .rdata    (rdata)
  );

  // R1: the block comes out of reset idle
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy);

  // R8: writes never occur while idle
  a_r8_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

endmodule

// File: tb/nor_erase_seq_tb.sv
`timescale 1ns/1ps
module nor_erase_seq_tb_top;

  localparam int AW  = 11;
  localparam int D   = 16;
  localparam int CPW = 2;
  localparam int RUN = 2 * D * CPW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy;

  int errors = 0;
  int checks = 0;
  int busy_cnt = 0;

  logic [10:0] cyc_a [6];
  logic [15:0] cyc_d [6];

  always #2 clk = ~clk;

  always @(posedge clk) if (busy) busy_cnt <= busy_cnt + 1;

  nor_erase_seq #(.ADDR_W(AW), .WORDS(D), .CYC_PER_WORD(CPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input int a, output logic [15:0] q);
    rd_en = 1'b1; addr = AW'(a);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic send_full();
    for (int s = 0; s < 6; s++) do_write(cyc_a[s], cyc_d[s]);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
  endtask

  function automatic logic [15:0] power_up(input int i);
    logic [15:0] v = 16'h4C21;
    for (int k = 0; k < i; k++) v = v + 16'h0137;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] q;
    cyc_a[0] = 11'h555; cyc_d[0] = 16'h00AA;
    cyc_a[1] = 11'h2AA; cyc_d[1] = 16'h0055;
    cyc_a[2] = 11'h555; cyc_d[2] = 16'h0080;
    cyc_a[3] = 11'h555; cyc_d[3] = 16'h00AA;
    cyc_a[4] = 11'h2AA; cyc_d[4] = 16'h0055;
    cyc_a[5] = 11'h555; cyc_d[5] = 16'h0010;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and power-up contents
    check(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    for (int i = 0; i < D; i++) begin
      do_read(i, q);
      check(q == power_up(i), "R1 power-up word", 32'(q), 32'(power_up(i)));
    end

    // R3: a bad address or bad data at every position blocks the erase
    for (int pos = 0; pos < 6; pos++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int s = 0; s < 6; s++) begin
          if (s == pos)
            do_write(kind == 0 ? (cyc_a[s] ^ 11'h001) : cyc_a[s],
                     kind == 1 ? (cyc_d[s] ^ 16'h0100) : cyc_d[s]);
          else
            do_write(cyc_a[s], cyc_d[s]);
        end
        check(busy == 1'b0, "R3 mismatch no erase", 32'(busy), 0);
      end
    end
    do_read(5, q);
    check(q == power_up(5), "R3 array unchanged", 32'(q), 32'(power_up(5)));

    // R9: hardware reset mid-command clears the tracker
    for (int s = 0; s < 3; s++) do_write(cyc_a[s], cyc_d[s]);
    hw_reset = 1'b1; @(negedge clk); hw_reset = 1'b0;
    for (int s = 3; s < 6; s++) do_write(cyc_a[s], cyc_d[s]);
    check(busy == 1'b0, "R9 tail alone no erase", 32'(busy), 0);

    // R8: abort in the zero pass and in the wipe pass
    for (int trial = 0; trial < 2; trial++) begin
      int t;
      int n;
      t = (trial == 0) ? (D * CPW / 2 + 1) : (D * CPW + 3 * CPW + 1);
      n = t / CPW;
      send_full();
      check(busy == 1'b1, "R2 busy after sixth write", 32'(busy), 1);
      repeat (t) @(negedge clk);
      hw_reset = 1'b1; @(negedge clk); hw_reset = 1'b0;
      check(busy == 1'b0, "R8 busy cleared by hw_reset", 32'(busy), 0);
      for (int i = 0; i < D; i++) begin
        logic [15:0] e;
        if (n <= D) e = (i < n) ? 16'h0000 : power_up(i);
        else        e = (i < n - D) ? 16'hFFFF : 16'h0000;
        do_read(i, q);
        check(q == e, "R8 partial array", 32'(q), 32'(e));
      end
    end

    // R2 R4 R7: full run, exact busy length, all ones afterwards
    busy_cnt = 0;
    send_full();
    check(busy == 1'b1, "R2 busy after sixth write", 32'(busy), 1);
    wait_idle();
    check(busy_cnt == RUN, "R4 busy length", 32'(busy_cnt), 32'(RUN));
    for (int i = 0; i < D; i++) begin
      do_read(i, q);
      check(q == 16'hFFFF, "R7 erased word", 32'(q), 32'hFFFF);
    end

    // R5 R6: status reads and ignored writes during a run
    busy_cnt = 0;
    send_full();
    for (int r = 0; r < 4; r++) begin
      logic [15:0] e;
      e = (r % 2 == 1) ? 16'h0044 : 16'h0000;
      do_read(r, q);
      check(q == e, "R5 status word", 32'(q), 32'(e));
    end
    send_full();
    for (int s = 0; s < 5; s++) do_write(cyc_a[s], cyc_d[s]);
    do_read(0, q);
    check(q == 16'h0000, "R5 status after busy writes", 32'(q), 0);
    wait_idle();
    check(busy_cnt == RUN, "R6 writes did not extend run", 32'(busy_cnt), 32'(RUN));
    do_write(cyc_a[5], cyc_d[5]);
    check(busy == 1'b0, "R6 no command state kept", 32'(busy), 0);
    do_read(3, q);
    check(q == 16'hFFFF, "R7 read mode after run", 32'(q), 32'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule